// File: doc/BRIEF.md
# Banked Internal Data Memory Resolver

This block is the internal data store of a small 8-bit controller core. It also holds the logic that turns an operand into a physical location. Each request carries an access mode, an 8-bit operand field and the two bank bits from the core's status word. The resolver forms a physical byte index from these inputs and then does one of two things: it performs the access on a 256-byte RAM, or it forwards the access to the special-function-register (SFR) port.

A register operand is formed from the bank bits and a 3-bit register number, which gives four banks of eight registers. For an indirect access, the pointer is taken from register 0 or register 1 of the bank that is selected at that moment. Addresses below 0x80 reach the same bytes in both direct and indirect mode. Above 0x80 the two modes part: direct accesses go to the SFR space, and indirect accesses go to a separate upper RAM half. A bit mode reads, sets or clears single flags in a 16-byte window.

Each request is resolved and registered in the cycle it is presented, and a write by that request also commits at that edge. The read result appears in the following cycle, driven combinationally from the registered location. An SFR result comes back from the core on `sfr_rdata`, qualified by `sfr_ack`.

Top module: `banked_dmem`

## Requirements
- R1: `req_mode` is encoded as 0 = register, 1 = direct, 2 = indirect, 3 = bit. A register access with register number `req_addr[2:0]` reaches RAM byte `bank_sel*8 + req_addr[2:0]`, using the bank bits presented with that request. The bytes of banks that are not selected are preserved.
- R2: Direct and indirect accesses to addresses 0x00 to 0x7F reach the same RAM byte.
- R3: An indirect access to 0x80 to 0xFF reads or writes upper RAM. It raises no SFR request, and it is independent of any SFR access to the same address.
- R4: A direct access to 0x80 to 0xFF leaves RAM unchanged. In the next cycle it drives `sfr_req`=1, `sfr_addr`=`req_addr[6:0]`, and `sfr_we`/`sfr_wdata` equal to the request's write flag and data.
- R5: An indirect access uses as its address the byte in register 0 of the current bank when `req_addr[0]`=0, and in register 1 when it is 1. Bits `req_addr[7:1]` are ignored.
- R6: A bit access selects byte 0x20 + `req_addr[6:3]` and bit position `req_addr[2:0]`; `req_addr[7]` is ignored. In the next cycle `rbit` returns that bit and `rdata` returns the whole byte.
- R7: A bit write replaces only the addressed bit with `req_bitval` and leaves the other seven bits unchanged.
- R8: The cycle after a request, `rvalid` is 1 for a RAM access, and `rdata` shows the addressed byte including any write made by that same request. For an SFR access, `rvalid` follows `sfr_ack` and `rdata` equals `sfr_rdata`. In a cycle after no request, `rvalid` is 0.
- R9: While reset is held and until it is released, `rvalid` and `sfr_req` are 0. RAM contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_mode | input | 2 | Access mode (see R1) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register number, address, pointer select or bit address |
| req_wdata | input | 8 | Byte write data |
| req_bitval | input | 1 | Bit write value |
| bank_sel | input | 2 | Bank bits from the status word |
| rvalid | output | 1 | Read result valid |
| rdata | output | 8 | Read byte |
| rbit | output | 1 | Read bit for bit accesses |
| sfr_req | output | 1 | SFR access request |
| sfr_we | output | 1 | SFR write |
| sfr_addr | output | 7 | SFR offset within 0x80 to 0xFF |
| sfr_wdata | output | 8 | SFR write data |
| sfr_ack | input | 1 | SFR access completed |
| sfr_rdata | input | 8 | SFR read data |

## Verification
Two functions can meet in back-to-back cycles, and each meeting is provoked deliberately. In the first, a register write puts a new value into R0, and an indirect access through R0 follows in the very next cycle; that access must already use the new pointer. In the second, a bit write to a flag byte is followed at once by a read of the same byte; the read must show exactly one bit changed. The bench's behavioural model applies every write in request order and predicts each output one cycle later, so both cases are judged by comparing the outputs against the model on every clock.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int DM_AW = 8;  // operand / physical index width
  localparam int DM_DW = 8;  // data width
  localparam int DM_BW = 2;  // bank-select width
  localparam int DM_RW = 3;  // register-select width
  localparam int DM_PW = $clog2(DM_DW);

  typedef enum logic [1:0] {
    ACC_REG = 2'd0,
    ACC_DIR = 2'd1,
    ACC_IND = 2'd2,
    ACC_BIT = 2'd3
  } acc_mode_e;

  typedef struct packed {
    logic [DM_AW-1:0] phys;
    logic             to_sfr;
    logic             bit_op;
    logic [DM_PW-1:0] pos;
  } acc_loc_t;

endpackage

// File: rtl/dmem_resolve.sv
module dmem_resolve
  import dmem_pkg::*;
#(
  parameter int AW = DM_AW,
  parameter int BW = DM_BW,
  parameter int RW = DM_RW,
  parameter int PW = DM_PW,
  parameter logic [AW-1:0] BIT_BASE = 'h20
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] bank,
  input  logic [AW-1:0] ptr_byte,
  output logic [AW-1:0] ptr_idx,
  output acc_loc_t      loc
);

  localparam int PAD_W = RW - 1;

  // pointer register is R0 or R1 of the live bank
  assign ptr_idx = AW'({bank, {PAD_W{1'b0}}, addr[0]});

  always_comb begin
    loc = '0;
    case (acc_mode_e'(mode))
      ACC_REG: loc.phys = AW'({bank, addr[RW-1:0]});
      ACC_DIR: begin
        loc.phys   = addr;
        loc.to_sfr = addr[AW-1];
      end
      ACC_IND: loc.phys = ptr_byte;
      ACC_BIT: begin
        loc.phys   = BIT_BASE + AW'(addr[AW-2:PW]);
        loc.pos    = addr[PW-1:0];
        loc.bit_op = 1'b1;
      end
      default: loc = '0;
    endcase
  end

endmodule

// File: rtl/dmem_array.sv
module dmem_array #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW,
  localparam int PW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ptr_idx,
  output logic [DW-1:0] ptr_q,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_q,
  input  logic          byte_we,
  input  logic          bit_we,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] bit_pos,
  input  logic          bit_val
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] merged;
  logic [DW-1:0] wr_byte;
  logic          wr_en;

  assign ptr_q = mem[ptr_idx];
  assign rd_q  = mem[rd_idx];

  // single-cycle read-modify-write for flag updates
  always_comb begin
    merged          = mem[wr_idx];
    merged[bit_pos] = bit_val;
    wr_byte         = bit_we ? merged : wr_data;
    wr_en           = byte_we | bit_we;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_byte;
    end
  end

  assert_bit_rmw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_we |=> ($countones(mem[$past(wr_idx)] ^ $past(mem[wr_idx])) <= 1));

endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
  import dmem_pkg::*;
#(
  parameter int AW = DM_AW,
  parameter int DW = DM_DW,
  parameter int BW = DM_BW,
  parameter int RW = DM_RW,
  parameter logic [AW-1:0] BIT_BASE = 'h20,
  localparam int PW = $clog2(DW),
  localparam int BIT_BYTES = 1 << (AW - 1 - PW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_mode,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_bitval,
  input  logic [BW-1:0] bank_sel,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic          rbit,
  output logic          sfr_req,
  output logic          sfr_we,
  output logic [AW-2:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic          sfr_ack,
  input  logic [DW-1:0] sfr_rdata
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic [AW-1:0] ptr_idx;
  logic [DW-1:0] ptr_byte;
  logic [DW-1:0] rd_q;
  acc_loc_t      loc;

  dmem_resolve #(.AW(AW), .BW(BW), .RW(RW), .PW(PW), .BIT_BASE(BIT_BASE)) u_res (
    .mode     (req_mode),
    .addr     (req_addr),
    .bank     (bank_sel),
    .ptr_byte (AW'(ptr_byte)),
    .ptr_idx  (ptr_idx),
    .loc      (loc)
  );

  // write steering
  logic byte_we, bit_we;
  always_comb begin
    byte_we = req_valid & req_we & ~loc.to_sfr & ~loc.bit_op;
    bit_we  = req_valid & req_we & loc.bit_op;
  end

  // registered read location and SFR handshake
  logic          vld_q, vld_n;
  logic          sel_sfr_q, sel_sfr_n;
  logic          sreq_q, sreq_n;
  logic          swe_q, swe_n;
  logic [AW-1:0] idx_q;
  logic [PW-1:0] pos_q;
  logic [AW-2:0] saddr_q;
  logic [DW-1:0] swdata_q;

  dmem_array #(.AW(AW), .DW(DW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .ptr_idx (ptr_idx),
    .ptr_q   (ptr_byte),
    .rd_idx  (idx_q),
    .rd_q    (rd_q),
    .byte_we (byte_we),
    .bit_we  (bit_we),
    .wr_idx  (loc.phys),
    .wr_data (req_wdata),
    .bit_pos (loc.pos),
    .bit_val (req_bitval)
  );

  always_comb begin
    vld_n     = req_valid;
    sel_sfr_n = req_valid & loc.to_sfr;
    sreq_n    = req_valid & loc.to_sfr;
    swe_n     = req_valid & loc.to_sfr & req_we;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q     <= 1'b0;
      sel_sfr_q <= 1'b0;
      sreq_q    <= 1'b0;
      swe_q     <= 1'b0;
    end else begin
      vld_q     <= vld_n;
      sel_sfr_q <= sel_sfr_n;
      sreq_q    <= sreq_n;
      swe_q     <= swe_n;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      idx_q    <= loc.phys;
      pos_q    <= loc.pos;
      saddr_q  <= req_addr[AW-2:0];
      swdata_q <= req_wdata;
    end
  end

  always_comb begin
    rvalid    = vld_q & (~sel_sfr_q | sfr_ack);
    rdata     = sel_sfr_q ? sfr_rdata : rd_q;
    rbit      = rd_q[pos_q];
    sfr_req   = sreq_q;
    sfr_we    = swe_q;
    sfr_addr  = saddr_q;
    sfr_wdata = swdata_q;
  end

  assert_sfr_source_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    sfr_req |-> $past(req_valid && req_mode == ACC_DIR && req_addr[AW-1]));

  assert_ind_upper_ram_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && req_mode == ACC_IND) |=> !sfr_req);

  assert_bit_window_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && req_mode == ACC_BIT) |->
      (loc.phys >= BIT_BASE && loc.phys < BIT_BASE + AW'(BIT_BYTES)));

  assert_ram_rvalid_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && !(req_mode == ACC_DIR && req_addr[AW-1])) |=> rvalid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    !req_valid |=> (!rvalid && !sfr_req));

endmodule

// File: tb/sim_banked_dmem.sv
module sim_banked_dmem;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_mode;
  logic       req_we;
  logic [7:0] req_addr;
  logic [7:0] req_wdata;
  logic       req_bitval;
  logic [1:0] bank_sel;
  logic       rvalid;
  logic [7:0] rdata;
  logic       rbit;
  logic       sfr_req;
  logic       sfr_we;
  logic [6:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic       sfr_ack;
  logic [7:0] sfr_rdata;
  logic       ack_en;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit closed = 0;

  logic [7:0] mem_m [256];

  always #4 clk = ~clk;

  banked_dmem u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bitval(req_bitval), .bank_sel(bank_sel), .rvalid(rvalid),
    .rdata(rdata), .rbit(rbit), .sfr_req(sfr_req), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_ack(sfr_ack),
    .sfr_rdata(sfr_rdata)
  );

  // SFR responder
  assign sfr_ack   = sfr_req & ack_en;
  assign sfr_rdata = {1'b0, sfr_addr} ^ 8'hA5;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!closed) begin
      closed = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // one request; model updated at the edge, outputs compared at the next negedge
  task automatic op(input logic [1:0] m, input logic [7:0] a, input logic w,
                    input logic [7:0] d, input logic b, input logic [1:0] bk,
                    input string tag);
    logic [7:0] phys;
    logic [2:0] pos;
    logic       tosfr;
    req_valid = 1'b1; req_mode = m; req_addr = a; req_we = w;
    req_wdata = d; req_bitval = b; bank_sel = bk;
    @(posedge clk);
    tosfr = 1'b0; pos = 3'd0; phys = 8'd0;
    case (m)
      2'd0: phys = {3'b000, bk, a[2:0]};
      2'd1: begin phys = a; tosfr = a[7]; end
      2'd2: phys = mem_m[{3'b000, bk, 2'b00, a[0]}];
      default: begin phys = 8'h20 + {4'b0000, a[6:3]}; pos = a[2:0]; end
    endcase
    if (w && !tosfr) begin
      if (m == 2'd3) mem_m[phys][pos] = b;
      else           mem_m[phys] = d;
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (tosfr) begin
      chk(sfr_req == 1'b1, tag, "sfr_req", sfr_req, 1);
      chk(sfr_addr == a[6:0], tag, "sfr_addr", sfr_addr, a[6:0]);
      chk(sfr_we == w, tag, "sfr_we", sfr_we, w);
      if (w) chk(sfr_wdata == d, tag, "sfr_wdata", sfr_wdata, d);
      chk(rvalid == ack_en, "R8", "sfr rvalid", rvalid, ack_en);
      if (ack_en && !w)
        chk(rdata == ({1'b0, a[6:0]} ^ 8'hA5), "R8", "sfr rdata", rdata,
            {1'b0, a[6:0]} ^ 8'hA5);
    end else begin
      chk(sfr_req == 1'b0, tag, "no sfr_req", sfr_req, 0);
      chk(rvalid == 1'b1, tag, "rvalid", rvalid, 1);
      chk(rdata == mem_m[phys], tag, "rdata", rdata, mem_m[phys]);
      if (m == 2'd3) chk(rbit == mem_m[phys][pos], tag, "rbit", rbit, mem_m[phys][pos]);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(rvalid == 1'b0, "R8", "idle rvalid", rvalid, 0);
    chk(sfr_req == 1'b0, "R8", "idle sfr_req", sfr_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; req_we = 1'b0;
    req_addr = 8'd0; req_wdata = 8'd0; req_bitval = 1'b0; bank_sel = 2'd0;
    ack_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(rvalid == 1'b0, "R9", "reset rvalid", rvalid, 0);
    chk(sfr_req == 1'b0, "R9", "reset sfr_req", sfr_req, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // fill low half directly, upper half through R0
    for (int i = 0; i < 128; i++) op(2'd1, 8'(i), 1, 8'((i * 7 + 3) & 255), 0, 0, "R2");
    for (int i = 128; i < 256; i++) begin
      op(2'd0, 8'd0, 1, 8'(i), 0, 0, "R1");
      op(2'd2, 8'd0, 1, 8'(i) ^ 8'h3C, 0, 0, "R3");
    end
    idle();

    // R1: banked registers
    op(2'd0, 8'd5, 1, 8'h3C, 0, 2, "R1");
    op(2'd0, 8'd5, 0, 8'h00, 0, 0, "R1");
    op(2'd1, 8'h15, 0, 8'h00, 0, 0, "R1");
    op(2'd0, 8'd5, 1, 8'h77, 0, 3, "R1");
    op(2'd0, 8'd5, 0, 8'h00, 0, 2, "R1");
    op(2'd0, 8'hFD, 0, 8'h00, 0, 1, "R1");

    // R2 and R5: low half via pointer R1 of bank 0
    op(2'd1, 8'h40, 1, 8'h91, 0, 0, "R2");
    op(2'd0, 8'd1, 1, 8'h40, 0, 0, "R5");
    op(2'd2, 8'hFF, 0, 8'h00, 0, 0, "R2");
    op(2'd2, 8'h01, 1, 8'h66, 0, 0, "R2");
    op(2'd1, 8'h40, 0, 8'h00, 0, 0, "R2");
    op(2'd0, 8'd0, 1, 8'h44, 0, 1, "R5");
    op(2'd0, 8'd1, 1, 8'hC8, 0, 1, "R5");
    op(2'd2, 8'hFE, 0, 8'h00, 0, 1, "R5");
    op(2'd2, 8'h01, 0, 8'h00, 0, 1, "R5");

    // R3 / R4: same upper address, two stores
    op(2'd1, 8'h90, 1, 8'hDE, 0, 0, "R4");
    op(2'd0, 8'd0, 1, 8'h90, 0, 0, "R3");
    op(2'd2, 8'h00, 0, 8'h00, 0, 0, "R3");
    op(2'd2, 8'h00, 1, 8'h12, 0, 0, "R3");
    op(2'd1, 8'h90, 0, 8'h00, 0, 0, "R4");
    op(2'd2, 8'h00, 0, 8'h00, 0, 0, "R3");
    ack_en = 1'b0;
    op(2'd1, 8'hC3, 0, 8'h00, 0, 0, "R8");
    ack_en = 1'b1;
    idle();

    // R8 collision: pointer written then used on the next cycle
    op(2'd0, 8'd0, 1, 8'h4C, 0, 0, "R8");
    op(2'd2, 8'h00, 0, 8'h00, 0, 0, "R8");
    op(2'd0, 8'd0, 1, 8'hF1, 0, 0, "R8");
    op(2'd2, 8'h00, 1, 8'h5A, 0, 0, "R8");

    // R6 / R7: flag bits
    op(2'd1, 8'h2A, 1, 8'h0F, 0, 0, "R7");
    op(2'd3, 8'h57, 1, 8'h00, 1, 0, "R7");
    op(2'd1, 8'h2A, 0, 8'h00, 0, 0, "R7");
    op(2'd3, 8'h50, 1, 8'h00, 0, 0, "R7");
    op(2'd3, 8'hD0, 0, 8'h00, 0, 0, "R6");
    op(2'd3, 8'h53, 0, 8'h00, 0, 0, "R6");
    op(2'd3, 8'h00, 0, 8'h00, 0, 0, "R6");
    op(2'd3, 8'h7F, 1, 8'h00, 1, 0, "R6");
    op(2'd1, 8'h2F, 0, 8'h00, 0, 0, "R6");
    op(2'd3, 8'hFF, 1, 8'hFF, 0, 0, "R6");
    op(2'd3, 8'h7F, 0, 8'h00, 0, 0, "R6");

    // R9: reset in mid-run keeps RAM
    op(2'd1, 8'hA0, 0, 8'h00, 0, 0, "R4");
    rst_n = 1'b0;
    @(negedge clk);
    chk(rvalid == 1'b0, "R9", "mid reset rvalid", rvalid, 0);
    chk(sfr_req == 1'b0, "R9", "mid reset sfr_req", sfr_req, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    op(2'd1, 8'h40, 0, 8'h00, 0, 0, "R9");
    op(2'd0, 8'd5, 0, 8'h00, 0, 3, "R9");
    op(2'd2, 8'h00, 0, 8'h00, 0, 0, "R9");
    idle();

    summary();
  end

endmodule